// File: doc/BRIEF.md
# Raw JTAG Vector Shifter

This block drives a JTAG bus without a TAP controller of its own. A remote controller loads two bit vectors, one for TMS and one for TDI, sets a scan length and a TCK rate, and issues a go command. The block then replays both vectors bit for bit on TMS and TDI while it toggles TCK, and it captures TDO into a receive vector. All bus-state sequencing comes from the caller's TMS vector. A scan longer than one vector is split into several go commands. Between them TCK stays low and TMS/TDI keep their last values, so the segments join into one continuous scan.

The block can also pulse an active-low target reset line. The pulse width is a whole number of TCK periods, set by the caller. While that pulse is active the block refuses to scan. A done flag tells the controller that the last bit of a scan has been shifted.

Top module: `jtag_vector_shifter`

## Requirements
- R1: After reset, tck_o, tms_o, tdi_o, busy_o and done_o are 0, trst_n_o is 1 and rx_o is all zero.
- R2: A go command produces exactly N rising TCK edges, where N is the effective length. TCK is low whenever busy_o is 0. Each TCK half period lasts D+1 clock cycles, where D is the divider value (0..127), so busy_o is high for exactly 2*N*(D+1) cycles.
- R3: TMS and TDI bit k of the loaded vectors (bit 0 first) is put on tms_o/tdi_o at the falling edge (or at go, for k=0) that comes before rising TCK edge k. It stays stable while TCK is high.
- R4: tdo_i is sampled at rising TCK edge k and stored in rx_o bit k. A go command clears rx_o, so bits at N and above read 0.
- R5: The length field is 8 bits. Values 1..128 give that many bits. A value of 0, or any value above 128, gives 128 bits.
- R6: When the last bit has been shifted, TCK is low, busy_o drops, done_o rises, and tms_o/tdi_o keep the last bit shifted until the next go.
- R7: A pulse-reset command with width field W drives trst_n_o low for W+1 TCK periods, which is 2*(W+1)*(D+1) clock cycles. TCK stays low throughout.
- R8: A go command issued while the reset pulse is active or while a scan is running is refused. It causes no TCK edge and no change to done_o.
- R9: Commands are given by cmd_op_i when cmd_valid_i is 1: 1 loads TDI (cmd_data_i), 2 loads TMS (cmd_data_i), 3 sets length (cmd_data_i[7:0]), 4 sets the divider (cmd_data_i[6:0]), 5 is go, and 6 pulses reset (width in cmd_data_i[7:0]). Load, length and divider commands are ignored while busy_o is 1.
- R10: done_o is cleared when a go command is accepted and stays 0 while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_data_i | input | 128 | Command payload (vector, length, divider or width) |
| tck_o | output | 1 | JTAG test clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to target |
| tdo_i | input | 1 | JTAG data from target |
| trst_n_o | output | 1 | Active-low target reset pulse |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Last scan finished |
| rx_o | output | 128 | Captured TDO bits, bit k from rising edge k |

## Verification
Scans are run with random TMS, TDI and TDO patterns at random lengths and divider values. This shows that bit ordering, edge alignment and the half-period count hold across rates, not only at the fastest one. Directed scans cover the length field at 1, at 0 and at a value above 128, which tells clamping apart from truncation. One scan runs at the slowest divider. In one scan a length write and a second go are injected mid-scan; the following scan then shows that the length register did not change. Reset pulses of two widths are checked, one with a go attempted during the pulse, to separate the width arithmetic from the refusal rule.

// File: rtl/jvs_pkg.sv
package jvs_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_LOAD_TDI  = 3'd1,
    OP_LOAD_TMS  = 3'd2,
    OP_SET_LEN   = 3'd3,
    OP_SET_DIV   = 3'd4,
    OP_GO        = 3'd5,
    OP_PULSE_RST = 3'd6
  } jvs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_RST  = 2'd3
  } jvs_state_e;
endpackage

// File: rtl/jvs_halfcnt.sv
module jvs_halfcnt #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= div_i;
    else                          cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/jvs_txlane.sv
module jvs_txlane #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [VEC_W-1:0] data_i,
  input  logic             start_i,
  input  logic             advance_i,
  output logic             bit_o
);
  logic [VEC_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      bit_o <= 1'b0;
    end else begin
      if (load_i) sh_q <= data_i;
      else if (advance_i) sh_q <= sh_q >> 1;
      if (start_i) bit_o <= sh_q[0];
      else if (advance_i) bit_o <= sh_q[1];
    end
  end
endmodule

// File: rtl/jvs_rxcap.sv
module jvs_rxcap #(
  parameter int VEC_W = 128,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             capture_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             din_i,
  output logic [VEC_W-1:0] rx_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) rx_o <= '0;
    else if (capture_i) rx_o[idx_i] <= din_i;
  end
endmodule

// File: rtl/jtag_vector_shifter.sv
module jtag_vector_shifter #(
  parameter int VEC_W  = 128,
  parameter int DIV_W  = 7,
  parameter int RSTW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_op_i,
  input  logic [VEC_W-1:0] cmd_data_i,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  input  logic             tdo_i,
  output logic             trst_n_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [VEC_W-1:0] rx_o
);
  import jvs_pkg::*;

  localparam int IDX_W = $clog2(VEC_W);
  localparam int LEN_W = IDX_W + 1;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(VEC_W);

  jvs_state_e       state_q;
  jvs_op_e          op;
  logic [LEN_W-1:0] len_q, nbits;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] bitidx_q;
  logic [RSTW_W:0]  rcnt_q;
  logic             idle, go_acc, pulse_acc, cfg_wr, tick, last_bit, advance, capture;
  logic [1:0]       lane_bit;

  assign op        = jvs_op_e'(cmd_op_i);
  assign idle      = (state_q == ST_IDLE);
  assign go_acc    = cmd_valid_i && idle && (op == OP_GO);
  assign pulse_acc = cmd_valid_i && idle && (op == OP_PULSE_RST);
  assign cfg_wr    = cmd_valid_i && idle;
  assign nbits     = (len_q == '0 || len_q > FULL_LEN) ? FULL_LEN : len_q;
  assign last_bit  = ({1'b0, bitidx_q} == nbits - LEN_W'(1));
  assign advance   = (state_q == ST_HIGH) && tick && !last_bit;
  assign capture   = (state_q == ST_LOW) && tick;
  assign busy_o    = (state_q == ST_LOW) || (state_q == ST_HIGH);

  jvs_halfcnt #(.DIV_W(DIV_W)) u_half (
    .clk(clk), .rst(rst), .restart_i(go_acc || pulse_acc),
    .div_i(div_q), .tick_o(tick)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    localparam jvs_op_e LOAD_OP = (l == 0) ? OP_LOAD_TDI : OP_LOAD_TMS;
    jvs_txlane #(.VEC_W(VEC_W)) u_lane (
      .clk(clk), .rst(rst),
      .load_i(cfg_wr && (op == LOAD_OP)), .data_i(cmd_data_i),
      .start_i(go_acc), .advance_i(advance), .bit_o(lane_bit[l])
    );
  end
  assign tdi_o = lane_bit[0];
  assign tms_o = lane_bit[1];

  jvs_rxcap #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst(rst), .clear_i(go_acc), .capture_i(capture),
    .idx_i(bitidx_q), .din_i(tdo_i), .rx_o(rx_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      div_q <= '0;
    end else if (cfg_wr) begin
      if (op == OP_SET_LEN) len_q <= cmd_data_i[LEN_W-1:0];
      if (op == OP_SET_DIV) div_q <= cmd_data_i[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tck_o    <= 1'b0;
      trst_n_o <= 1'b1;
      done_o   <= 1'b0;
      bitidx_q <= '0;
      rcnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go_acc) begin
            state_q  <= ST_LOW;
            done_o   <= 1'b0;
            bitidx_q <= '0;
          end else if (pulse_acc) begin
            state_q  <= ST_RST;
            trst_n_o <= 1'b0;
            rcnt_q   <= {cmd_data_i[RSTW_W-1:0], 1'b1};
          end
        end
        ST_LOW: begin
          if (tick) begin
            tck_o   <= 1'b1;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            tck_o <= 1'b0;
            if (last_bit) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
            end else begin
              state_q  <= ST_LOW;
              bitidx_q <= bitidx_q + 1'b1;
            end
          end
        end
        default: begin
          if (tick) begin
            if (rcnt_q == '0) begin
              trst_n_o <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              rcnt_q <= rcnt_q - 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_TCK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !tck_o); // R2
  AST_LINES_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tck_o && $past(tck_o)) |-> ($stable(tms_o) && $stable(tdi_o))); // R3
  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ({1'b0, bitidx_q} < nbits)); // R5
  AST_NO_SCAN_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    !trst_n_o |-> (!busy_o && !tck_o)); // R7
  AST_GO_REFUSED_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && op == OP_GO && state_q == ST_RST) |=> !busy_o); // R8
  AST_DONE_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !done_o); // R10
endmodule

// File: tb/sim_jtag_vector_shifter.sv
module sim_jtag_vector_shifter;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [VW-1:0] cmd_data = '0;
  logic          tck, tms, tdi, trst_n, busy, done;
  logic          tdo = 1'b0;
  logic [VW-1:0] rx;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [VW-1:0] cap_tms, cap_tdi, pat;
  int ncap = 0, kidx = 0;

  always #5 clk = ~clk;

  jtag_vector_shifter u0 (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_data_i(cmd_data), .tck_o(tck), .tms_o(tms), .tdi_o(tdi),
    .tdo_i(tdo), .trst_n_o(trst_n), .busy_o(busy), .done_o(done), .rx_o(rx)
  );

  always @(posedge tck) begin
    if (ncap < VW) begin
      cap_tms[ncap] = tms;
      cap_tdi[ncap] = tdi;
    end
    ncap++;
  end

  always @(negedge tck) begin
    kidx++;
    if (kidx < VW) tdo = pat[kidx];
  end

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic cmd(input int op, input logic [VW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
  endtask

  function automatic int eff_len(input int f);
    return (f == 0 || f > VW) ? VW : f;
  endfunction

  function automatic logic [VW-1:0] lo_mask(input int n);
    logic [VW-1:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // one scan; set_len=0 reuses the length already held; meddle injects commands mid-scan
  task automatic scan(input int len_field, input int div, input bit set_len,
                      input bit meddle, input int exp_len);
    logic [VW-1:0] vtdi, vtms, m;
    int n, cyc;
    vtdi = rnd_vec(); vtms = rnd_vec(); pat = rnd_vec();
    n = exp_len;
    m = lo_mask(n);
    cmd(4, VW'(div));
    if (set_len) cmd(3, VW'(len_field));
    cmd(1, vtdi);
    cmd(2, vtms);
    kidx = 0; tdo = pat[0]; ncap = 0; cap_tms = '0; cap_tdi = '0;
    cmd(5, '0);
    chk(done == 1'b0, "R10 done cleared at go", VW'(done), '0);
    cyc = 0;
    while (busy && cyc < 100000) begin
      cyc++;
      if (meddle && cyc == 3) begin cmd_valid = 1; cmd_op = 3'd3; cmd_data = VW'(5); end
      if (meddle && cyc == 4) begin cmd_op = 3'd5; cmd_data = '0; end
      if (meddle && cyc == 5) begin cmd_valid = 0; cmd_op = '0; end
      @(negedge clk);
    end
    chk(ncap == n, "R2/R5 tck rising edges", VW'(ncap), VW'(n));
    chk(cyc == 2 * n * (div + 1), "R2 busy cycles", VW'(cyc), VW'(2 * n * (div + 1)));
    chk((cap_tms & m) == (vtms & m), "R3 tms order", cap_tms & m, vtms & m);
    chk((cap_tdi & m) == (vtdi & m), "R3 tdi order", cap_tdi & m, vtdi & m);
    chk(rx == (pat & m), "R4 tdo capture", rx, pat & m);
    chk(done && !tck, "R6 done and tck low", {tck, done}, 2'b01);
    chk(tms == vtms[n-1] && tdi == vtdi[n-1], "R6 lines hold last bit",
        {tms, tdi}, {vtms[n-1], vtdi[n-1]});
    if (meddle) chk(ncap == n, "R8 go during scan refused", VW'(ncap), VW'(n));
  endtask

  task automatic pulse(input int w, input int div, input bit try_go);
    int cyc;
    bit done_before;
    cmd(4, VW'(div));
    done_before = done;
    ncap = 0;
    cmd(6, VW'(w));
    cyc = 0;
    while (!trst_n && cyc < 100000) begin
      cyc++;
      if (try_go && cyc == 2) begin cmd_valid = 1; cmd_op = 3'd5; end
      if (try_go && cyc == 3) begin cmd_valid = 0; cmd_op = '0; end
      @(negedge clk);
    end
    chk(cyc == 2 * (w + 1) * (div + 1), "R7 reset pulse width", VW'(cyc),
        VW'(2 * (w + 1) * (div + 1)));
    repeat (4) @(negedge clk);
    chk(ncap == 0 && !busy, "R7/R8 no tck during pulse, go refused", VW'(ncap), '0);
    chk(done == done_before, "R8 done unchanged by refused go", VW'(done), VW'(done_before));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int l, d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!tck && !tms && !tdi && trst_n && !busy && !done && rx == '0,
        "R1 reset state", {tck, tms, tdi, trst_n, busy, done}, 6'b000100);
    scan(1, 0, 1, 0, 1);                      // R5 shortest
    scan(0, 0, 1, 0, VW);                     // R5 zero means full
    scan(200, 1, 1, 0, VW);                   // R5 above range clamps
    scan(3, 127, 1, 0, 3);                    // R2 slowest rate
    scan(40, 2, 1, 1, 40);                    // R8 R9 mid-scan commands
    scan(0, 1, 0, 0, 40);                     // R9 length kept at 40
    for (int i = 0; i < 12; i++) begin
      l = 1 + ($urandom % VW);
      d = $urandom % 6;
      scan(l, d, 1, 0, eff_len(l));
    end
    pulse(3, 1, 1);                           // R7 R8
    pulse(0, 0, 0);                           // R7 narrowest
    scan(17, 0, 1, 0, 17);                    // usable again after pulse
    finish_run();
  end
endmodule